// File: doc/BRIEF.md
# Direct-Mapped Byte Cache Controller

This block sits between a processor that reads and writes single bytes and a slower main memory that moves one byte per request/acknowledge transfer. It keeps eight lines, each with a 4-byte block, a valid flag, a stored tag and a modified flag. A lookup that finds its block is answered from the line store. A lookup that misses fetches the whole block from memory, installs it, and then answers. Before the block is fetched, a modified line that is being displaced is first copied back to memory.

The `wb_mode` input picks the write policy and may change between requests. With it high, writes stay in the cache and mark the line modified. With it low, every write is also sent straight to memory and leaves the modified flag alone. Lines marked modified while `wb_mode` was high keep that mark until they are copied back. A one-cycle `flush_req` walks the line store in index order, copies back every valid modified line, and pulses `flush_done` when the walk ends.

Top module: `dm_byte_cache`

## Requirements
- R1: After reset no line is valid, and `cpu_ready`, `mem_req` and `flush_done` are low. The first access to any address therefore misses.
- R2: A CPU address splits into offset = bits [1:0], index = bits [4:2] and tag = bits [7:5]. Two addresses that differ only in the tag compete for the same line, and each evicts the other.
- R3: A read that hits returns the stored byte on `cpu_rdata` while `cpu_ready` is high for exactly one cycle. It causes no memory transfer.
- R4: A read miss reads the 4 bytes of the block-aligned block from memory in offset order 0,1,2,3. It installs them as a clean valid line and then returns the requested byte.
- R5: A write miss allocates the line: the block is refilled first and the CPU byte is then merged into it. The other three bytes keep their memory values.
- R6: With `wb_mode`=1, a write hit updates only the line store, makes no memory transfer, and marks the line modified.
- R7: Replacing a modified line first writes its 4 bytes to the old block address in offset order 0..3, and only then refills.
- R8: With `wb_mode`=0, every CPU write, hit or miss, writes exactly that byte to memory once. The line is not marked modified, so replacing it later writes nothing back.
- R9: A line marked modified under `wb_mode`=1 is still written back when it is replaced after `wb_mode` has been set to 0.
- R10: A flush writes back every valid modified line in ascending index order and clears each modified flag. `flush_done` then pulses for one cycle. A second flush with no writes in between makes no memory transfer.
- R11: If `flush_req` and `cpu_req` are both high while the controller is idle, the flush runs to completion first and the CPU request is served after it.
- R12: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady from the rise of `mem_req` until the cycle in which `mem_ack` is high. That cycle completes the transfer, and read data is taken from `mem_rdata` in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_mode | input | 1 | 1 = write-back, 0 = write-through |
| flush_req | input | 1 | One-cycle request to copy back all modified lines |
| flush_done | output | 1 | One-cycle pulse at the end of a flush |
| cpu_req | input | 1 | CPU request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 8 | CPU byte address |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | Read byte, valid while `cpu_ready` is high |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 8 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid with `mem_ack` |
| mem_ack | input | 1 | Memory transfer completion |

## Verification
A flush and a CPU access can arrive in the same idle cycle. The bench provokes this by raising `flush_req` and a `cpu_req` read together on one falling edge, with a modified line waiting at the read's index. The result is judged at the ports. `flush_done` must appear before `cpu_ready`. The memory must already hold the written byte. The read must return that byte as a hit, with no refill traffic.

// File: rtl/cache_pkg.sv
package cache_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int OFF_W  = 2;
    localparam int IDX_W  = 3;
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COMPARE,
        ST_WRITEBACK,
        ST_REFILL,
        ST_WTHRU,
        ST_RESPOND,
        ST_FLUSH
    } ctrl_state_e;

    typedef struct packed {
        ctrl_state_e         st;
        logic [ADDR_W-1:0]   addr;
        logic                we;
        logic [DATA_W-1:0]   wdata;
        logic [OFF_W-1:0]    beat;
        logic [IDX_W-1:0]    fidx;
        logic                flushing;
        logic [DATA_W-1:0]   rdata;
        logic                done;
    } ctrl_regs_t;
endpackage

// File: rtl/cache_store.sv
module cache_store #(
    parameter int IDX_W  = cache_pkg::IDX_W,
    parameter int OFF_W  = cache_pkg::OFF_W,
    parameter int TAG_W  = cache_pkg::TAG_W,
    parameter int DATA_W = cache_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic [OFF_W-1:0]  off,
    input  logic [TAG_W-1:0]  tag_in,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic              install,
    input  logic              dirty_set,
    input  logic              dirty_clr,
    output logic              line_valid,
    output logic              line_dirty,
    output logic [TAG_W-1:0]  line_tag,
    output logic [DATA_W-1:0] rd_byte
);
    localparam int LINES = 1 << IDX_W;
    localparam int BYTES = LINES << OFF_W;

    logic [LINES-1:0]  valid_q, valid_d, dirty_q, dirty_d;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [TAG_W-1:0]  tag_d  [LINES];
    logic [DATA_W-1:0] data_q [BYTES];
    logic [DATA_W-1:0] data_d [BYTES];

    assign line_valid = valid_q[idx];
    assign line_dirty = dirty_q[idx];
    assign line_tag   = tag_q[idx];
    assign rd_byte    = data_q[{idx, off}];

    always_comb begin
        valid_d = valid_q;
        dirty_d = dirty_q;
        tag_d   = tag_q;
        data_d  = data_q;
        if (wr_en)
            data_d[{idx, off}] = wr_byte;
        if (install) begin
            tag_d[idx]   = tag_in;
            valid_d[idx] = 1'b1;
            dirty_d[idx] = 1'b0;
        end
        if (dirty_set)
            dirty_d[idx] = 1'b1;
        if (dirty_clr)
            dirty_d[idx] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            valid_q <= valid_d;
            dirty_q <= dirty_d;
        end
    end

    always_ff @(posedge clk) begin
        tag_q  <= tag_d;
        data_q <= data_d;
    end
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
    import cache_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_mode,
    input  logic              flush_req,
    output logic              flush_done,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic [IDX_W-1:0]  s_idx,
    output logic [OFF_W-1:0]  s_off,
    output logic [TAG_W-1:0]  s_tag,
    output logic              s_wr_en,
    output logic [DATA_W-1:0] s_wr_byte,
    output logic              s_install,
    output logic              s_dirty_set,
    output logic              s_dirty_clr,
    input  logic              s_valid,
    input  logic              s_dirty,
    input  logic [TAG_W-1:0]  s_line_tag,
    input  logic [DATA_W-1:0] s_rd_byte
);
    ctrl_regs_t r_q, r_d;
    logic       hit;
    logic       beat_phase;

    assign beat_phase = (r_q.st == ST_WRITEBACK) || (r_q.st == ST_REFILL);
    assign s_idx      = r_q.flushing ? r_q.fidx : r_q.addr[OFF_W +: IDX_W];
    assign s_off      = beat_phase ? r_q.beat : r_q.addr[OFF_W-1:0];
    assign s_tag      = r_q.addr[ADDR_W-1 -: TAG_W];
    assign hit        = s_valid && (s_line_tag == s_tag);
    assign s_wr_byte  = (r_q.st == ST_REFILL) ? mem_rdata : r_q.wdata;

    assign mem_req    = beat_phase || (r_q.st == ST_WTHRU);
    assign mem_we     = (r_q.st != ST_REFILL);
    assign mem_wdata  = (r_q.st == ST_WRITEBACK) ? s_rd_byte : r_q.wdata;
    always_comb begin
        case (r_q.st)
            ST_WRITEBACK: mem_addr = {s_line_tag, s_idx, r_q.beat};
            ST_REFILL:    mem_addr = {s_tag, s_idx, r_q.beat};
            default:      mem_addr = r_q.addr;
        endcase
    end

    assign cpu_ready  = (r_q.st == ST_RESPOND);
    assign cpu_rdata  = r_q.rdata;
    assign flush_done = r_q.done;

    always_comb begin
        r_d         = r_q;
        r_d.done    = 1'b0;
        s_wr_en     = 1'b0;
        s_install   = 1'b0;
        s_dirty_set = 1'b0;
        s_dirty_clr = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (flush_req) begin
                    r_d.flushing = 1'b1;
                    r_d.fidx     = '0;
                    r_d.st       = ST_FLUSH;
                end else if (cpu_req) begin
                    r_d.addr  = cpu_addr;
                    r_d.we    = cpu_we;
                    r_d.wdata = cpu_wdata;
                    r_d.st    = ST_COMPARE;
                end
            end
            ST_COMPARE: begin
                r_d.beat = '0;
                if (hit) begin
                    if (!r_q.we) begin
                        r_d.rdata = s_rd_byte;
                        r_d.st    = ST_RESPOND;
                    end else begin
                        s_wr_en     = 1'b1;
                        s_dirty_set = wb_mode;
                        r_d.st      = wb_mode ? ST_RESPOND : ST_WTHRU;
                    end
                end else begin
                    r_d.st = (s_valid && s_dirty) ? ST_WRITEBACK : ST_REFILL;
                end
            end
            ST_WRITEBACK: begin
                if (mem_ack) begin
                    r_d.beat = r_q.beat + 1'b1;
                    if (&r_q.beat) begin
                        if (r_q.flushing) begin
                            s_dirty_clr = 1'b1;
                            if (&r_q.fidx) begin
                                r_d.flushing = 1'b0;
                                r_d.done     = 1'b1;
                                r_d.st       = ST_IDLE;
                            end else begin
                                r_d.fidx = r_q.fidx + 1'b1;
                                r_d.st   = ST_FLUSH;
                            end
                        end else begin
                            r_d.st = ST_REFILL;
                        end
                    end
                end
            end
            ST_REFILL: begin
                if (mem_ack) begin
                    s_wr_en  = 1'b1;
                    r_d.beat = r_q.beat + 1'b1;
                    if (&r_q.beat) begin
                        s_install = 1'b1;
                        r_d.st    = ST_COMPARE;
                    end
                end
            end
            ST_WTHRU: begin
                if (mem_ack)
                    r_d.st = ST_RESPOND;
            end
            ST_RESPOND: r_d.st = ST_IDLE;
            ST_FLUSH: begin
                r_d.beat = '0;
                if (s_valid && s_dirty) begin
                    r_d.st = ST_WRITEBACK;
                end else if (&r_q.fidx) begin
                    r_d.flushing = 1'b0;
                    r_d.done     = 1'b1;
                    r_d.st       = ST_IDLE;
                end else begin
                    r_d.fidx = r_q.fidx + 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assert_ready_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    assert_install_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
        s_install |=> (s_valid && !s_dirty && hit));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |=> (!flush_done && !mem_req));
endmodule

// File: rtl/dm_byte_cache.sv
module dm_byte_cache
    import cache_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_mode,
    input  logic              flush_req,
    output logic              flush_done,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    logic [IDX_W-1:0]  s_idx;
    logic [OFF_W-1:0]  s_off;
    logic [TAG_W-1:0]  s_tag, s_line_tag;
    logic              s_wr_en, s_install, s_dirty_set, s_dirty_clr;
    logic              s_valid, s_dirty;
    logic [DATA_W-1:0] s_wr_byte, s_rd_byte;

    cache_ctrl u_ctrl (
        .clk, .rst_n, .wb_mode, .flush_req, .flush_done,
        .cpu_req, .cpu_we, .cpu_addr, .cpu_wdata, .cpu_rdata, .cpu_ready,
        .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .mem_ack,
        .s_idx, .s_off, .s_tag, .s_wr_en, .s_wr_byte, .s_install,
        .s_dirty_set, .s_dirty_clr, .s_valid, .s_dirty, .s_line_tag, .s_rd_byte
    );

    cache_store #(
        .IDX_W(IDX_W), .OFF_W(OFF_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_store (
        .clk, .rst_n,
        .idx(s_idx), .off(s_off), .tag_in(s_tag),
        .wr_en(s_wr_en), .wr_byte(s_wr_byte), .install(s_install),
        .dirty_set(s_dirty_set), .dirty_clr(s_dirty_clr),
        .line_valid(s_valid), .line_dirty(s_dirty),
        .line_tag(s_line_tag), .rd_byte(s_rd_byte)
    );
endmodule

// File: tb/dm_byte_cache_bench.sv
`timescale 1ns/1ps
module dm_byte_cache_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wb_mode = 1'b1;
    logic       flush_req = 1'b0;
    logic       flush_done;
    logic       cpu_req = 1'b0;
    logic       cpu_we = 1'b0;
    logic [7:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       cpu_ready;
    logic       mem_req, mem_we;
    logic [7:0] mem_addr, mem_wdata;
    logic [7:0] mem_rdata;
    logic       mem_ack;

    int total = 0;
    int bad = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int hold_err = 0;
    logic [7:0] mem  [256];
    logic [7:0] rlog [64];
    logic [7:0] wlog [64];
    logic       prev_wait;
    logic [7:0] prev_addr;

    always #2.5 clk = ~clk;

    dm_byte_cache u_dm_byte_cache (
        .clk, .rst_n, .wb_mode, .flush_req, .flush_done,
        .cpu_req, .cpu_we, .cpu_addr, .cpu_wdata, .cpu_rdata, .cpu_ready,
        .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .mem_ack
    );

    function automatic logic [7:0] pat(input logic [7:0] a);
        return a ^ 8'h5A;
    endfunction

    // memory model: one wait cycle per byte, ack completes the transfer
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            prev_wait <= 1'b0;
            prev_addr <= '0;
            for (int i = 0; i < 256; i++) mem[i] <= pat(i[7:0]);
        end else begin
            // R12: address must not move while a request waits
            if (prev_wait && (!mem_req || mem_addr != prev_addr)) hold_err <= hold_err + 1;
            prev_wait <= mem_req && !mem_ack;
            prev_addr <= mem_addr;
            if (mem_req && !mem_ack) begin
                mem_ack   <= 1'b1;
                mem_rdata <= mem[mem_addr];
            end else begin
                mem_ack <= 1'b0;
                if (mem_req && mem_ack) begin
                    if (mem_we) begin
                        mem[mem_addr] <= mem_wdata;
                        wlog[wr_cnt[5:0]] <= mem_addr;
                        wr_cnt <= wr_cnt + 1;
                    end else begin
                        rlog[rd_cnt[5:0]] <= mem_addr;
                        rd_cnt <= rd_cnt + 1;
                    end
                end
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cpu_op(input logic we, input logic [7:0] a, input logic [7:0] d,
                          output logic [7:0] q);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        do @(negedge clk); while (!cpu_ready);
        q = cpu_rdata;
        cpu_req = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush_req = 1'b1;
        @(negedge clk);
        flush_req = 1'b0;
        while (!flush_done) @(negedge clk);
        @(negedge clk);
        check("R10 done one cycle", int'(flush_done), 0);
    endtask

    task automatic t_reset();
        check("R1 ready low", int'(cpu_ready), 0);
        check("R1 mem_req low", int'(mem_req), 0);
        check("R1 flush_done low", int'(flush_done), 0);
    endtask

    task automatic t_read();
        logic [7:0] q; int r0;
        r0 = rd_cnt;
        cpu_op(1'b0, 8'h26, 8'h00, q);
        check("R1 first access misses", rd_cnt - r0, 4);
        check("R4 miss data", q, pat(8'h26));
        check("R4 first refill addr", rlog[r0[5:0]], 8'h24);
        check("R4 last refill addr", rlog[(r0 + 3) & 63], 8'h27);
        r0 = rd_cnt;
        cpu_op(1'b0, 8'h27, 8'h00, q);
        check("R3 hit data", q, pat(8'h27));
        check("R3 hit no traffic", rd_cnt - r0, 0);
        @(negedge clk);
        check("R3 ready one cycle", int'(cpu_ready), 0);
    endtask

    task automatic t_writeback();
        logic [7:0] q; int w0, r0;
        wb_mode = 1'b1;
        w0 = wr_cnt;
        cpu_op(1'b1, 8'h25, 8'hAB, q);
        check("R6 write hit no mem write", wr_cnt - w0, 0);
        check("R6 memory untouched", mem[8'h25], pat(8'h25));
        cpu_op(1'b0, 8'h25, 8'h00, q);
        check("R6 cached value", q, 8'hAB);
        w0 = wr_cnt; r0 = rd_cnt;
        cpu_op(1'b0, 8'hA5, 8'h00, q);
        check("R7 evict writes 4", wr_cnt - w0, 4);
        check("R7 first wb addr", wlog[w0[5:0]], 8'h24);
        check("R7 last wb addr", wlog[(w0 + 3) & 63], 8'h27);
        check("R7 wb data", mem[8'h25], 8'hAB);
        check("R2 same index other tag", q, pat(8'hA5));
        check("R2 refill after wb", rd_cnt - r0, 4);
    endtask

    task automatic t_alloc();
        logic [7:0] q; int w0, r0;
        w0 = wr_cnt; r0 = rd_cnt;
        cpu_op(1'b1, 8'h42, 8'h77, q);
        check("R5 refill on write miss", rd_cnt - r0, 4);
        check("R5 no mem write", wr_cnt - w0, 0);
        cpu_op(1'b0, 8'h43, 8'h00, q);
        check("R5 neighbour byte", q, pat(8'h43));
        cpu_op(1'b0, 8'h42, 8'h00, q);
        check("R5 merged byte", q, 8'h77);
    endtask

    task automatic t_wthru();
        logic [7:0] q; int w0, r0;
        wb_mode = 1'b0;
        w0 = wr_cnt;
        cpu_op(1'b1, 8'h61, 8'h99, q);
        check("R9 old dirty line written back", wr_cnt - w0, 5);
        check("R9 wb data", mem[8'h42], 8'h77);
        check("R8 miss write through", mem[8'h61], 8'h99);
        check("R8 single byte last", wlog[(w0 + 4) & 63], 8'h61);
        w0 = wr_cnt;
        cpu_op(1'b0, 8'h01, 8'h00, q);
        check("R8 clean line no wb", wr_cnt - w0, 0);
        check("R8 read after evict", q, pat(8'h01));
        w0 = wr_cnt; r0 = rd_cnt;
        cpu_op(1'b1, 8'h01, 8'h3C, q);
        check("R8 hit one write", wr_cnt - w0, 1);
        check("R8 hit no refill", rd_cnt - r0, 0);
        check("R8 hit mem value", mem[8'h01], 8'h3C);
    endtask

    task automatic t_flush();
        logic [7:0] q; int w0;
        wb_mode = 1'b1;
        cpu_op(1'b1, 8'h88, 8'h11, q);
        cpu_op(1'b1, 8'hEC, 8'h22, q);
        w0 = wr_cnt;
        do_flush();
        check("R10 flush writes", wr_cnt - w0, 8);
        check("R10 index order first", wlog[w0[5:0]], 8'h88);
        check("R10 index order second", wlog[(w0 + 4) & 63], 8'hEC);
        check("R10 data a", mem[8'h88], 8'h11);
        check("R10 data b", mem[8'hEC], 8'h22);
        w0 = wr_cnt;
        do_flush();
        check("R10 second flush silent", wr_cnt - w0, 0);
    endtask

    task automatic t_collide();
        logic [7:0] q; int r0; bit seen_done;
        wb_mode = 1'b1;
        cpu_op(1'b1, 8'h90, 8'h33, q);
        seen_done = 0;
        r0 = rd_cnt;
        @(negedge clk);
        flush_req = 1'b1; cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h90;
        @(negedge clk);
        flush_req = 1'b0;
        while (!cpu_ready) begin
            if (flush_done) seen_done = 1;
            @(negedge clk);
        end
        q = cpu_rdata;
        cpu_req = 1'b0;
        check("R11 flush before cpu", int'(seen_done), 1);
        check("R11 flushed data", mem[8'h90], 8'h33);
        check("R11 cpu read hit", q, 8'h33);
        check("R11 no refill", rd_cnt - r0, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_read();
        t_writeback();
        t_alloc();
        t_wthru();
        t_flush();
        t_collide();
        check("R12 request held until ack", hold_err, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule